// File: doc/BRIEF.md
# Serial Interface Host Register and Interrupt Block

This block is the processor-facing register file of an asynchronous serial interface. It decodes a three-line chip select, a register-select line, a read/write line and an access strobe onto four registers. Writes go to a control register or to the transmit holding register. Reads return the status word or the receive holding register. The control fields drive the external serial engines. They set the clock divider and word format, request-to-send, break and the engine hold that master reset applies.

The receive engine hands over each character with a one-cycle push strobe, together with its framing and parity flags. The transmit engine takes the held character with a one-cycle take strobe whenever the pending output is high. The block tracks the modem inputs through a parameterised synchroniser. It latches any loss of carrier and drives an active-low interrupt line.

Top module: `acia_host_regs`

## Requirements
- R1: A register access happens only in a cycle where cs_hi0 and cs_hi1 are 1, cs_lo_n is 0 and bus_en is 1; in any other cycle a write changes no output.
- R2: reg_sel=1 with rd_nwr=0 writes the transmit holding register, reg_sel=1 with rd_nwr=1 reads the receive holding register, reg_sel=0 with rd_nwr=0 writes the control register and reg_sel=0 with rd_nwr=1 reads the status word; rdata shows the receive holding register when reg_sel=1 and the status word when reg_sel=0.
- R3: div_sel follows control bits 1:0 and word_fmt follows control bits 4:2. Control bits 1:0 = 11 is master reset. It sets engine_hold and clears the receive-full, overrun, framing, parity and carrier latch flags. It sets transmit-empty and holds all of this until a control write with bits 1:0 other than 11. After reset the block is in master reset.
- R4: Control bits 6:5 give: 00 rts_n=0 with no transmit interrupt; 01 rts_n=0 with transmit interrupt; 10 rts_n=1 with no transmit interrupt; 11 rts_n=0 with no transmit interrupt and tx_break=1 (break only outside master reset).
- R5: Status bits from 0 to 7 are: receive full, transmit empty, carrier lost, clear-to-send input level, framing error, overrun, parity error, interrupt active (the inverse of irq_n).
- R6: A push outside master reset with receive-full 0 loads the receive holding register and the framing and parity flags and sets receive-full; a read of the receive holding register clears receive-full; framing and parity stay with the character.
- R7: A push while receive-full is 1 and no data read occurs sets overrun and keeps the older character; a data read clears overrun.
- R8: A transmit holding write makes transmit-empty 0, tx_pending 1 and tx_data the written byte; tx_take sets transmit-empty again; while cts_n is high the transmit-empty status bit reads 0 and status bit 3 reads 1.
- R9: A low-to-high edge on dcd_n sets a carrier latch; status bit 2 is the latch OR the dcd_n level; the latch clears only by a status read with the latch set followed by a data read, or by master reset.
- R10: irq_n is 0 outside master reset when control bit 7 is 1 and any of receive-full, overrun or the carrier latch is set, or when control bits 6:5 are 01 and the transmit-empty status bit is 1.
- R11: During master reset, pushes, takes and transmit holding writes are ignored and irq_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_hi0 | input | 1 | Chip select, active high |
| cs_hi1 | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| bus_en | input | 1 | Access strobe, one cycle per access |
| reg_sel | input | 1 | 1 = data registers, 0 = control/status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rx_push | input | 1 | Receive engine delivers a character |
| rx_data | input | 8 | Received character |
| rx_fe | input | 1 | Framing error of the pushed character |
| rx_pe | input | 1 | Parity error of the pushed character |
| tx_take | input | 1 | Transmit engine takes the held character |
| tx_data | output | 8 | Held transmit character |
| tx_pending | output | 1 | A character waits for the transmitter |
| tx_break | output | 1 | Send break |
| div_sel | output | 2 | Clock divide field |
| word_fmt | output | 3 | Word format field |
| engine_hold | output | 1 | Master reset active |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The properties assume that bus_en is a single-cycle pulse per access and that no control write coincides with a data-register access, since one strobe selects one register. They also assume the engine strobes are single-cycle. The stimulus drives every access through one task that raises bus_en for exactly one cycle and then drops it. It changes the modem inputs only between accesses and waits out the synchroniser depth before it looks at their effect.

// File: rtl/acia_pkg.sv
package acia_pkg;
   localparam int unsigned ST_RXFULL  = 0;
   localparam int unsigned ST_TXEMPTY = 1;
   localparam int unsigned ST_CARRIER = 2;
   localparam int unsigned ST_CTS     = 3;
   localparam int unsigned ST_FRAME   = 4;
   localparam int unsigned ST_OVERRUN = 5;
   localparam int unsigned ST_PARITY  = 6;
   localparam int unsigned ST_IRQ     = 7;

   typedef enum logic [1:0] {
      DIV_1 = 2'b00, DIV_16 = 2'b01, DIV_64 = 2'b10, DIV_MRESET = 2'b11
   } div_e;

   typedef enum logic [1:0] {
      TXC_RTS_LO   = 2'b00,
      TXC_RTS_LO_I = 2'b01,
      TXC_RTS_HI   = 2'b10,
      TXC_BREAK    = 2'b11
   } txctl_e;

   typedef struct packed {
      logic       rx_ie;
      txctl_e     txc;
      logic [2:0] fmt;
      div_e       div;
   } ctrl_t;
endpackage

// File: rtl/acia_bus_decode.sv
module acia_bus_decode (
   input  logic cs_hi0,
   input  logic cs_hi1,
   input  logic cs_lo_n,
   input  logic bus_en,
   input  logic reg_sel,
   input  logic rd_nwr,
   output logic wr_ctrl,
   output logic wr_tdr,
   output logic rd_stat,
   output logic rd_rdr
);
   logic hit;
   assign hit     = cs_hi0 & cs_hi1 & ~cs_lo_n & bus_en;
   assign wr_ctrl = hit & ~reg_sel & ~rd_nwr;
   assign rd_stat = hit & ~reg_sel &  rd_nwr;
   assign wr_tdr  = hit &  reg_sel & ~rd_nwr;
   assign rd_rdr  = hit &  reg_sel &  rd_nwr;
endmodule

// File: rtl/acia_sync.sv
module acia_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d} ;
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/acia_rx_side.sv
module acia_rx_side #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_fe,
   input  logic              rx_pe,
   input  logic              rd_stat,
   input  logic              rd_rdr,
   input  logic              dcd_s,
   output logic [DATA_W-1:0] rdr,
   output logic              rdrf,
   output logic              ovrn,
   output logic              fe,
   output logic              pe,
   output logic              dcd_latch
);
   logic dcd_q, armed, rise;
   assign rise = dcd_s & ~dcd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dcd_q <= 1'b0;
      else        dcd_q <= dcd_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdr <= '0; rdrf <= 1'b0; ovrn <= 1'b0; fe <= 1'b0; pe <= 1'b0;
         dcd_latch <= 1'b0; armed <= 1'b0;
      end else if (hold) begin
         rdrf <= 1'b0; ovrn <= 1'b0; fe <= 1'b0; pe <= 1'b0;
         dcd_latch <= 1'b0; armed <= 1'b0;
      end else begin
         if (rd_rdr) begin
            rdrf <= 1'b0;
            ovrn <= 1'b0;
         end
         if (rx_push) begin
            if (rdrf && !rd_rdr) begin
               ovrn <= 1'b1;
            end else begin
               rdr  <= rx_data;
               rdrf <= 1'b1;
               fe   <= rx_fe;
               pe   <= rx_pe;
            end
         end
         if (rd_stat && dcd_latch) armed <= 1'b1;
         if (rd_rdr && armed) begin
            dcd_latch <= 1'b0;
            armed     <= 1'b0;
         end
         if (rise) begin
            dcd_latch <= 1'b1;
            armed     <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/acia_tx_side.sv
module acia_tx_side #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              wr_tdr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tx_take,
   output logic [DATA_W-1:0] tdr,
   output logic              tdr_empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr       <= '0;
         tdr_empty <= 1'b1;
      end else if (hold) begin
         tdr_empty <= 1'b1;
      end else if (wr_tdr) begin
         tdr       <= wdata;
         tdr_empty <= 1'b0;
      end else if (tx_take) begin
         tdr_empty <= 1'b1;
      end
   end
endmodule

// File: rtl/acia_host_regs.sv
module acia_host_regs #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi0,
   input  logic              cs_hi1,
   input  logic              cs_lo_n,
   input  logic              bus_en,
   input  logic              reg_sel,
   input  logic              rd_nwr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_fe,
   input  logic              rx_pe,
   input  logic              tx_take,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_pending,
   output logic              tx_break,
   output logic [1:0]        div_sel,
   output logic [2:0]        word_fmt,
   output logic              engine_hold,
   input  logic              cts_n,
   input  logic              dcd_n,
   output logic              rts_n,
   output logic              irq_n
);
   import acia_pkg::*;

   localparam int unsigned STAT_W = 8;

   generate
      if (DATA_W != STAT_W) begin : g_bad_width
         $error("acia_host_regs: DATA_W must equal the status width of 8");
      end
   endgenerate

   logic wr_ctrl, wr_tdr, rd_stat, rd_rdr;
   logic cts_s, dcd_s;
   logic hold, tie, rie, irq, tdre_stat;
   logic rdrf, ovrn, fe, pe, dcd_latch, tdr_empty;
   logic [DATA_W-1:0] rdr, tdr;
   logic [STAT_W-1:0] status;
   ctrl_t ctrl;

   acia_bus_decode u_dec (
      .cs_hi0(cs_hi0), .cs_hi1(cs_hi1), .cs_lo_n(cs_lo_n), .bus_en(bus_en),
      .reg_sel(reg_sel), .rd_nwr(rd_nwr),
      .wr_ctrl(wr_ctrl), .wr_tdr(wr_tdr), .rd_stat(rd_stat), .rd_rdr(rd_rdr)
   );

   acia_sync #(.STAGES(SYNC_STAGES)) u_sync_cts (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
   );
   acia_sync #(.STAGES(SYNC_STAGES)) u_sync_dcd (
      .clk(clk), .rst_n(rst_n), .d(dcd_n), .q(dcd_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= '{rx_ie: 1'b0, txc: TXC_RTS_LO, fmt: 3'b000, div: DIV_MRESET};
      else if (wr_ctrl) ctrl <= ctrl_t'(wdata);
   end

   assign hold = (ctrl.div == DIV_MRESET);
   assign rie  = ctrl.rx_ie;
   assign tie  = (ctrl.txc == TXC_RTS_LO_I);

   acia_rx_side #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .rx_push(rx_push), .rx_data(rx_data), .rx_fe(rx_fe), .rx_pe(rx_pe),
      .rd_stat(rd_stat), .rd_rdr(rd_rdr), .dcd_s(dcd_s),
      .rdr(rdr), .rdrf(rdrf), .ovrn(ovrn), .fe(fe), .pe(pe), .dcd_latch(dcd_latch)
   );

   acia_tx_side #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .wr_tdr(wr_tdr), .wdata(wdata), .tx_take(tx_take),
      .tdr(tdr), .tdr_empty(tdr_empty)
   );

   assign tdre_stat = tdr_empty & ~cts_s;
   assign irq = ~hold & ((rie & (rdrf | ovrn | dcd_latch)) | (tie & tdre_stat));

   always_comb begin
      status             = '0;
      status[ST_RXFULL]  = rdrf;
      status[ST_TXEMPTY] = tdre_stat;
      status[ST_CARRIER] = dcd_latch | dcd_s;
      status[ST_CTS]     = cts_s;
      status[ST_FRAME]   = fe;
      status[ST_OVERRUN] = ovrn;
      status[ST_PARITY]  = pe;
      status[ST_IRQ]     = irq;
   end

   assign rdata       = reg_sel ? rdr : status;
   assign irq_n       = ~irq;
   assign tx_data     = tdr;
   assign tx_pending  = ~tdr_empty;
   assign tx_break    = (ctrl.txc == TXC_BREAK) & ~hold;
   assign rts_n       = (ctrl.txc == TXC_RTS_HI);
   assign div_sel     = ctrl.div;
   assign word_fmt    = ctrl.fmt;
   assign engine_hold = hold;
endmodule

// File: rtl/acia_host_chk.sv
module acia_host_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_ctrl,
   input logic       wr_tdr,
   input logic       rd_rdr,
   input logic [7:0] wdata,
   input logic       rx_push,
   input logic       hold,
   input logic       rdrf,
   input logic       tdr_empty,
   input logic       rts_n,
   input logic       irq_n
);
   p_mreset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && wdata[1:0] == 2'b11 |=> hold);

   p_rts_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && wdata[6:5] == 2'b10 |=> rts_n);

   p_push_sets_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hold && !wr_ctrl && rx_push |=> rdrf);

   p_read_clears_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hold && rd_rdr && !rx_push |=> !rdrf);

   p_tdr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold && wr_tdr |=> !tdr_empty);

   p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold && $past(hold) |-> tdr_empty && !rdrf && irq_n);
endmodule

bind acia_host_regs acia_host_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_tdr(wr_tdr), .rd_rdr(rd_rdr),
   .wdata(wdata), .rx_push(rx_push), .hold(hold), .rdrf(rdrf),
   .tdr_empty(tdr_empty), .rts_n(rts_n), .irq_n(irq_n)
);

// File: tb/tb_acia_host_regs.sv
module tb_acia_host_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {ctrl byte, div_sel, word_fmt, rts_n, tx_break, irq_n}
   localparam logic [15:0] VEC [NVEC] = '{
      {8'h15, 2'b01, 3'b101, 1'b0, 1'b0, 1'b1},
      {8'h35, 2'b01, 3'b101, 1'b0, 1'b0, 1'b0},
      {8'h55, 2'b01, 3'b101, 1'b1, 1'b0, 1'b1},
      {8'h75, 2'b01, 3'b101, 1'b0, 1'b1, 1'b1},
      {8'h02, 2'b10, 3'b000, 1'b0, 1'b0, 1'b1},
      {8'h1E, 2'b10, 3'b111, 1'b0, 1'b0, 1'b1},
      {8'h29, 2'b01, 3'b010, 1'b0, 1'b0, 1'b0},
      {8'h4C, 2'b00, 3'b011, 1'b1, 1'b0, 1'b1}
   };

   logic clk = 0, rst_n = 0;
   logic cs_hi0 = 1, cs_hi1 = 1, cs_lo_n = 0, bus_en = 0, reg_sel = 0, rd_nwr = 1;
   logic [7:0] wdata = 0, rdata, rx_data = 0, tx_data;
   logic rx_push = 0, rx_fe = 0, rx_pe = 0, tx_take = 0;
   logic tx_pending, tx_break, engine_hold, rts_n, irq_n;
   logic cts_n = 0, dcd_n = 0;
   logic [1:0] div_sel;
   logic [2:0] word_fmt;
   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   acia_host_regs dut (
      .clk(clk), .rst_n(rst_n), .cs_hi0(cs_hi0), .cs_hi1(cs_hi1), .cs_lo_n(cs_lo_n),
      .bus_en(bus_en), .reg_sel(reg_sel), .rd_nwr(rd_nwr), .wdata(wdata), .rdata(rdata),
      .rx_push(rx_push), .rx_data(rx_data), .rx_fe(rx_fe), .rx_pe(rx_pe),
      .tx_take(tx_take), .tx_data(tx_data), .tx_pending(tx_pending), .tx_break(tx_break),
      .div_sel(div_sel), .word_fmt(word_fmt), .engine_hold(engine_hold),
      .cts_n(cts_n), .dcd_n(dcd_n), .rts_n(rts_n), .irq_n(irq_n)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic rs, input logic [7:0] d);
      @(negedge clk); reg_sel = rs; rd_nwr = 0; wdata = d; bus_en = 1;
      @(negedge clk); bus_en = 0; rd_nwr = 1;
   endtask

   task automatic bus_rd(input logic rs, output logic [7:0] d);
      @(negedge clk); reg_sel = rs; rd_nwr = 1; bus_en = 1;
      #1 d = rdata;
      @(negedge clk); bus_en = 0;
   endtask

   task automatic peek_status(output logic [7:0] d);
      reg_sel = 0; rd_nwr = 1; #1 d = rdata;
   endtask

   task automatic push(input logic [7:0] d, input logic f, input logic p);
      @(negedge clk); rx_data = d; rx_fe = f; rx_pe = p; rx_push = 1;
      @(negedge clk); rx_push = 0;
   endtask

   task automatic take();
      @(negedge clk); tx_take = 1;
      @(negedge clk); tx_take = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      check("R3 reset hold", {7'b0, engine_hold}, 8'h01);
      check("R10 reset irq_n", {7'b0, irq_n}, 8'h01);
      peek_status(rv); check("R5 reset status", rv, 8'h02);

      // R1: writes with a deselected chip are ignored
      cs_lo_n = 1; bus_wr(0, 8'h55);
      check("R1 cs_lo_n high ignored", {6'b0, rts_n, engine_hold}, 8'h01);
      cs_lo_n = 0; cs_hi0 = 0; bus_wr(0, 8'h55);
      check("R1 cs_hi0 low ignored", {6'b0, rts_n, engine_hold}, 8'h01);
      cs_hi0 = 1;

      // R3 R4 R10: control table
      for (int i = 0; i < NVEC; i++) begin
         bus_wr(0, VEC[i][15:8]);
         check("R3 div_sel", {6'b0, div_sel}, {6'b0, VEC[i][7:6]});
         check("R3 word_fmt", {5'b0, word_fmt}, {5'b0, VEC[i][5:3]});
         check("R4 rts_n/break", {6'b0, rts_n, tx_break}, {6'b0, VEC[i][2:1]});
         check("R10 tx irq_n", {7'b0, irq_n}, {7'b0, VEC[i][0]});
         check("R3 hold released", {7'b0, engine_hold}, 8'h00);
      end

      // R6 receive path
      bus_wr(0, 8'h15);
      push(8'hA5, 1, 0);
      peek_status(rv); check("R6 full+fe status", rv, 8'h13);
      bus_rd(1, rv); check("R2 R6 data read", rv, 8'hA5);
      @(negedge clk); peek_status(rv); check("R6 full cleared", rv, 8'h12);

      // R7 overrun
      push(8'h11, 0, 1);
      push(8'h22, 0, 0);
      peek_status(rv); check("R7 overrun status", rv, 8'h63);
      bus_rd(1, rv); check("R7 older char kept", rv, 8'h11);
      @(negedge clk); peek_status(rv); check("R7 overrun cleared", rv, 8'h42);

      // R10 receive interrupt
      bus_wr(0, 8'h95);
      check("R10 rx irq idle", {7'b0, irq_n}, 8'h01);
      push(8'h33, 0, 0);
      check("R10 rx irq on", {7'b0, irq_n}, 8'h00);
      peek_status(rv); check("R5 irq bit7", rv, 8'h83);
      bus_rd(1, rv);
      @(negedge clk); check("R10 rx irq cleared by read", {7'b0, irq_n}, 8'h01);

      // R8 transmit path
      bus_wr(1, 8'h5A);
      check("R8 pending", {7'b0, tx_pending}, 8'h01);
      check("R8 tx_data", tx_data, 8'h5A);
      peek_status(rv); check("R8 tdre low", rv, 8'h00);
      take();
      peek_status(rv); check("R8 tdre after take", rv, 8'h02);
      check("R8 pending clear", {7'b0, tx_pending}, 8'h00);
      bus_wr(0, 8'h35);
      check("R10 tx irq on", {7'b0, irq_n}, 8'h00);
      bus_wr(1, 8'h01);
      check("R10 tx irq cleared by write", {7'b0, irq_n}, 8'h01);
      take();
      check("R10 tx irq again", {7'b0, irq_n}, 8'h00);
      cts_n = 1; repeat (5) @(negedge clk);
      peek_status(rv); check("R8 cts masks tdre", rv, 8'h08);
      check("R8 R10 cts irq off", {7'b0, irq_n}, 8'h01);
      cts_n = 0; repeat (5) @(negedge clk);

      // R9 carrier latch
      bus_wr(0, 8'h95);
      dcd_n = 1; repeat (5) @(negedge clk);
      peek_status(rv); check("R9 carrier set", rv, 8'h86);
      dcd_n = 0; repeat (5) @(negedge clk);
      peek_status(rv); check("R9 latch held", rv, 8'h86);
      bus_rd(1, rv);
      @(negedge clk); peek_status(rv); check("R9 data read alone keeps", rv, 8'h86);
      bus_rd(0, rv); check("R9 status read", rv, 8'h86);
      bus_rd(1, rv);
      @(negedge clk); peek_status(rv); check("R9 latch cleared", rv, 8'h02);
      check("R9 irq cleared", {7'b0, irq_n}, 8'h01);

      // R3 R9 master reset clears latch, bit follows pin
      dcd_n = 1; repeat (5) @(negedge clk);
      bus_wr(0, 8'h03);
      @(negedge clk); peek_status(rv); check("R3 R9 mreset follows pin", rv, 8'h06);
      check("R11 irq in hold", {7'b0, irq_n}, 8'h01);
      bus_wr(0, 8'h95);
      @(negedge clk); check("R9 no irq without edge", {7'b0, irq_n}, 8'h01);
      dcd_n = 0; repeat (5) @(negedge clk);
      peek_status(rv); check("R9 follows pin low", rv, 8'h02);

      // R11 hold ignores engines and writes
      bus_wr(0, 8'h03);
      @(negedge clk);
      push(8'h44, 0, 0);
      peek_status(rv); check("R11 push ignored", rv, 8'h02);
      bus_wr(1, 8'h77);
      check("R11 tdr write ignored", {7'b0, tx_pending}, 8'h00);
      bus_wr(0, 8'h75);
      check("R4 R11 break released with hold", {6'b0, tx_break, tx_pending}, 8'h02);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule